// File: doc/BRIEF.md
# Four-Road Junction Signal Sequencer

This block drives the lamps at a crossing of four roads that also has one pedestrian crossing. The roads get right of way one after another. The road being served shows green, then yellow, and then returns to red. In the same cycle that it returns to red, the next road turns green. Once the last road has cleared there is a short all-red gap, and then the pedestrian crossing gets its walk phase. After that the rotation starts again from the first road.

Each road has a vehicle presence input. If the served road's input stays low long enough, its green ends early, but never before a minimum green time has elapsed. Every phase length is a parameter counted in clock cycles. The lamp outputs are decoded directly from the sequencer state, with no register between them.

Top module: `tl_junction_ctrl`

## Requirements
- R1: Each road lamp field is 5 bits wide. The codes are green 10011, yellow 01000 and red 00100. Road n (n = 1 to 4) drives bits [5n-1:5n-5] of `road_lamp`.
- R2: The pedestrian lamp shows 0000 for walk and 1111 for stop, and no other value.
- R3: Reset is synchronous and active high. In the cycle after any reset edge, road 1 is green, roads 2 to 4 are red and the pedestrian lamp is stop. All timers start from zero, so road 1 then receives a full green.
- R4: While vehicles keep arriving, a road stays green for GREEN_CYC cycles and then yellow for YELLOW_CYC cycles. It then turns red in the same cycle that the next road turns green.
- R5: Roads are served in the order 1, 2, 3, 4.
- R6: After road 4's yellow, all roads and the pedestrian lamp are red for CLEAR_CYC cycles. The pedestrian lamp then shows walk for WALK_CYC cycles, after which road 1 turns green.
- R7: At most one road is non-red at any time. The pedestrian lamp shows stop whenever any road is non-red.
- R8: A road's sensor may stay low for IDLE_CYC consecutive sampled cycles while that road is green. In that case, once the green has lasted at least MIN_GREEN_CYC cycles, the road turns yellow on the next cycle.
- R9: A green lasts at least MIN_GREEN_CYC cycles, even when the road has had no traffic since before its green began.
- R10: A green is always followed by yellow on the same road. A road never goes directly from green to red.
- R11: The sensors of roads that are not being served have no effect on the served road's green length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| veh_sense | input | ROADS (4) | Vehicle present, one bit per road, bit 0 = road 1 |
| road_lamp | output | 5*ROADS (20) | Road lamp codes, 5 bits per road |
| walk_lamp | output | 4 | Pedestrian lamp code |

## Verification
The main rotation is run with every sensor held high. With no early exit possible, the bench checks the fixed green, yellow, all-red and walk lengths, and both cycle edges of each phase change. A second pattern drops only road 1's sensor part-way through its green. This tells the idle timeout apart from the full green length, because the exit cycle depends on when the sensor fell.

A third pattern keeps only road 2's sensor low. This shows that road 1's green is not affected by another road's sensor, and that road 2's green is cut back to the minimum rather than to zero. A reset applied in the middle of the rotation shows that the timers clear, because road 1 then receives its whole green again.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int LAMP_W = 5;
    localparam int WALK_W = 4;

    typedef logic [LAMP_W-1:0] lamp_t;
    typedef logic [WALK_W-1:0] walk_t;

    localparam lamp_t LAMP_GO   = 5'b10011;
    localparam lamp_t LAMP_WARN = 5'b01000;
    localparam lamp_t LAMP_STOP = 5'b00100;

    localparam walk_t WALK_GO   = 4'b0000;
    localparam walk_t WALK_STOP = 4'b1111;

    typedef enum logic [1:0] {
        PH_GREEN  = 2'd0,
        PH_YELLOW = 2'd1,
        PH_CLEAR  = 2'd2,
        PH_WALK   = 2'd3
    } phase_e;

    function automatic int tl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int tl_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tl_idle_watch.sv
module tl_idle_watch
    import tl_pkg::*;
#(
    parameter int ROADS    = 4,
    parameter int IDLE_CYC = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROADS-1:0] sense,
    output logic [ROADS-1:0] idle
);
    localparam int QW = tl_bits(IDLE_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(IDLE_CYC);

    for (genvar k = 0; k < ROADS; k++) begin : g_road
        logic [QW-1:0] quiet;

        always_ff @(posedge clk) begin
            if (rst) begin
                quiet <= '0;
            end else if (sense[k]) begin
                quiet <= '0;
            end else if (quiet != QMAX) begin
                quiet <= quiet + 1'b1;
            end
        end

        assign idle[k] = (quiet == QMAX);
    end

endmodule

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
    import tl_pkg::*;
#(
    parameter int ROADS         = 4,
    parameter int GREEN_CYC     = 20,
    parameter int MIN_GREEN_CYC = 6,
    parameter int YELLOW_CYC    = 4,
    parameter int CLEAR_CYC     = 3,
    parameter int WALK_CYC      = 10,
    localparam int RW           = tl_bits(ROADS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROADS-1:0] idle,
    output phase_e           phase,
    output logic [RW-1:0]    road
);
    localparam int LONGEST = tl_max(tl_max(GREEN_CYC, YELLOW_CYC),
                                    tl_max(CLEAR_CYC, WALK_CYC));
    localparam int CW = tl_bits(LONGEST + 1);
    localparam logic [RW-1:0] LAST_ROAD = RW'(ROADS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [RW-1:0] road;
        logic [CW-1:0] elapsed;
    } seq_t;

    seq_t cur, nxt;
    logic done;
    logic idle_cur;

    assign idle_cur = idle[cur.road];

    always_comb begin
        unique case (cur.phase)
            PH_GREEN:  done = (cur.elapsed == CW'(GREEN_CYC - 1)) ||
                              ((cur.elapsed >= CW'(MIN_GREEN_CYC - 1)) && idle_cur);
            PH_YELLOW: done = (cur.elapsed == CW'(YELLOW_CYC - 1));
            PH_CLEAR:  done = (cur.elapsed == CW'(CLEAR_CYC - 1));
            default:   done = (cur.elapsed == CW'(WALK_CYC - 1));
        endcase
    end

    always_comb begin
        nxt = cur;
        if (!done) begin
            nxt.elapsed = cur.elapsed + 1'b1;
        end else begin
            nxt.elapsed = '0;
            unique case (cur.phase)
                PH_GREEN: nxt.phase = PH_YELLOW;
                PH_YELLOW: begin
                    if (cur.road == LAST_ROAD) begin
                        nxt.phase = PH_CLEAR;
                    end else begin
                        nxt.phase = PH_GREEN;
                        nxt.road  = cur.road + 1'b1;
                    end
                end
                PH_CLEAR: nxt.phase = PH_WALK;
                default: begin
                    nxt.phase = PH_GREEN;
                    nxt.road  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.phase   <= PH_GREEN;
            cur.road    <= '0;
            cur.elapsed <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign phase = cur.phase;
    assign road  = cur.road;

endmodule

// File: rtl/tl_lamp_drive.sv
module tl_lamp_drive
    import tl_pkg::*;
#(
    parameter int ROADS = 4,
    localparam int RW   = tl_bits(ROADS)
) (
    input  phase_e                  phase,
    input  logic [RW-1:0]           road,
    output logic [ROADS*LAMP_W-1:0] road_lamp,
    output walk_t                   walk_lamp
);
    for (genvar k = 0; k < ROADS; k++) begin : g_lamp
        logic served;
        assign served = (road == RW'(k));

        always_comb begin
            if (served && phase == PH_GREEN) begin
                road_lamp[k*LAMP_W +: LAMP_W] = LAMP_GO;
            end else if (served && phase == PH_YELLOW) begin
                road_lamp[k*LAMP_W +: LAMP_W] = LAMP_WARN;
            end else begin
                road_lamp[k*LAMP_W +: LAMP_W] = LAMP_STOP;
            end
        end
    end

    assign walk_lamp = (phase == PH_WALK) ? WALK_GO : WALK_STOP;

endmodule

// File: rtl/tl_junction_ctrl.sv
module tl_junction_ctrl
    import tl_pkg::*;
#(
    parameter int ROADS         = 4,
    parameter int GREEN_CYC     = 20,
    parameter int MIN_GREEN_CYC = 6,
    parameter int YELLOW_CYC    = 4,
    parameter int CLEAR_CYC     = 3,
    parameter int WALK_CYC      = 10,
    parameter int IDLE_CYC      = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ROADS-1:0]        veh_sense,
    output logic [ROADS*LAMP_W-1:0] road_lamp,
    output logic [WALK_W-1:0]       walk_lamp
);
    localparam int RW = tl_bits(ROADS);

    logic [ROADS-1:0] idle;
    phase_e           phase;
    logic [RW-1:0]    road;

    tl_idle_watch #(
        .ROADS    (ROADS),
        .IDLE_CYC (IDLE_CYC)
    ) u_idle (
        .clk   (clk),
        .rst   (rst),
        .sense (veh_sense),
        .idle  (idle)
    );

    tl_phase_seq #(
        .ROADS         (ROADS),
        .GREEN_CYC     (GREEN_CYC),
        .MIN_GREEN_CYC (MIN_GREEN_CYC),
        .YELLOW_CYC    (YELLOW_CYC),
        .CLEAR_CYC     (CLEAR_CYC),
        .WALK_CYC      (WALK_CYC)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .idle  (idle),
        .phase (phase),
        .road  (road)
    );

    tl_lamp_drive #(
        .ROADS (ROADS)
    ) u_drive (
        .phase     (phase),
        .road      (road),
        .road_lamp (road_lamp),
        .walk_lamp (walk_lamp)
    );

endmodule

// File: rtl/tl_junction_chk.sv
module tl_junction_chk
    import tl_pkg::*;
#(
    parameter int ROADS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ROADS*LAMP_W-1:0] road_lamp,
    input logic [WALK_W-1:0]       walk_lamp
);
    logic [ROADS-1:0] is_go, is_warn, is_stop;

    for (genvar k = 0; k < ROADS; k++) begin : g_flags
        assign is_go[k]   = (road_lamp[k*LAMP_W +: LAMP_W] == LAMP_GO);
        assign is_warn[k] = (road_lamp[k*LAMP_W +: LAMP_W] == LAMP_WARN);
        assign is_stop[k] = (road_lamp[k*LAMP_W +: LAMP_W] == LAMP_STOP);

        // R1
        road_code_chk: assert property (@(posedge clk) disable iff (rst)
            is_go[k] || is_warn[k] || is_stop[k]);

        // R10
        green_then_yellow_chk: assert property (@(posedge clk) disable iff (rst)
            is_go[k] |=> (is_go[k] || is_warn[k]));

        // R4
        yellow_then_red_chk: assert property (@(posedge clk) disable iff (rst)
            is_warn[k] |=> (is_warn[k] || is_stop[k]));
    end

    // R7
    one_road_moving_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~is_stop));

    // R7
    walk_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (~is_stop != '0) |-> (walk_lamp == WALK_STOP));

    // R2
    walk_code_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_lamp == WALK_GO) || (walk_lamp == WALK_STOP));

    // R3
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (is_go[0] && $countones(is_stop) == ROADS - 1 && walk_lamp == WALK_STOP));

endmodule

bind tl_junction_ctrl tl_junction_chk #(
    .ROADS (ROADS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .road_lamp (road_lamp),
    .walk_lamp (walk_lamp)
);

// File: tb/tl_junction_ctrl_test.sv
module tl_junction_ctrl_test;

    localparam logic [4:0] GRN = 5'b10011;
    localparam logic [4:0] YEL = 5'b01000;
    localparam logic [4:0] RED = 5'b00100;
    localparam logic [3:0] PGO = 4'b0000;
    localparam logic [3:0] PST = 4'b1111;
    localparam int NONE = 7;

    // entry: {edge[15:0], green road[2:0], yellow road[2:0], walk[0]}
    localparam int NV = 15;
    localparam logic [22:0] VEC [NV] = '{
        {16'd0,   3'd0, 3'd7, 1'b0},
        {16'd19,  3'd0, 3'd7, 1'b0},
        {16'd20,  3'd7, 3'd0, 1'b0},
        {16'd23,  3'd7, 3'd0, 1'b0},
        {16'd24,  3'd1, 3'd7, 1'b0},
        {16'd44,  3'd7, 3'd1, 1'b0},
        {16'd48,  3'd2, 3'd7, 1'b0},
        {16'd72,  3'd3, 3'd7, 1'b0},
        {16'd92,  3'd7, 3'd3, 1'b0},
        {16'd95,  3'd7, 3'd3, 1'b0},
        {16'd96,  3'd7, 3'd7, 1'b0},
        {16'd98,  3'd7, 3'd7, 1'b0},
        {16'd99,  3'd7, 3'd7, 1'b1},
        {16'd108, 3'd7, 3'd7, 1'b1},
        {16'd109, 3'd0, 3'd7, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  veh_sense = 4'b1111;
    logic [19:0] road_lamp;
    logic [3:0]  walk_lamp;

    int checks = 0;
    int errors = 0;
    int cur    = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    tl_junction_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .veh_sense (veh_sense),
        .road_lamp (road_lamp),
        .walk_lamp (walk_lamp)
    );

    function automatic logic [19:0] exp_roads(input int g, input int y);
        logic [19:0] v;
        for (int k = 0; k < 4; k++) begin
            v[k*5 +: 5] = (k == g) ? GRN : ((k == y) ? YEL : RED);
        end
        return v;
    endfunction

    task automatic check(input string rq, input int g, input int y, input bit walk);
        logic [19:0] er;
        logic [3:0]  ep;
        er = exp_roads(g, y);
        ep = walk ? PGO : PST;
        checks++;
        if (road_lamp !== er || walk_lamp !== ep) begin
            errors++;
            $display("FAIL %s edge %0d road_lamp=%b expected %b walk_lamp=%b expected %b",
                     rq, cur, road_lamp, er, walk_lamp, ep);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        cur = 0;
    endtask

    task automatic go_to(input int k);
        while (cur < k) begin
            @(posedge clk);
            cur++;
        end
        #2;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Full rotation with constant traffic: R1 R2 R4 R5 R6 codes
        @(posedge clk);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            go_to(int'(VEC[i][22:7]));
            check("R1 R2 R4 R5 R6", int'(VEC[i][6:4]), int'(VEC[i][3:1]), VEC[i][0]);
        end

        // R3: reset in the middle of road 2's green restores R1 with a full green
        veh_sense = 4'b1111;
        do_reset();
        go_to(30);
        check("R5", 1, NONE, 1'b0);
        do_reset();
        check("R3", 0, NONE, 1'b0);
        go_to(19);
        check("R3", 0, NONE, 1'b0);
        go_to(20);
        check("R3", NONE, 0, 1'b0);

        // R8: road 1 sensor falls so that edge 9 is the first quiet sample
        veh_sense = 4'b1111;
        do_reset();
        go_to(8);
        veh_sense = 4'b1110;
        go_to(13);
        check("R8", 0, NONE, 1'b0);
        go_to(14);
        check("R8 R10", NONE, 0, 1'b0);
        go_to(18);
        check("R4", 1, NONE, 1'b0);

        // R11: only road 2 is quiet; road 1 keeps its full green
        veh_sense = 4'b1101;
        do_reset();
        go_to(19);
        check("R11", 0, NONE, 1'b0);
        go_to(20);
        check("R11", NONE, 0, 1'b0);
        // R9: road 2 has been idle since before its green, so it keeps only the minimum green
        go_to(29);
        check("R9", 1, NONE, 1'b0);
        go_to(30);
        check("R9 R10", NONE, 1, 1'b0);
        go_to(34);
        check("R4 R5", 2, NONE, 1'b0);

        // R8: every sensor quiet from reset; road 1 leaves green after 6 cycles
        veh_sense = 4'b0000;
        do_reset();
        go_to(5);
        check("R8", 0, NONE, 1'b0);
        go_to(6);
        check("R8", NONE, 0, 1'b0);

        finish_run();
    end

endmodule